// File: doc/BRIEF.md
# Receiver Gain Switch with Exponential Hold-Off

This block chooses the gain of a receiver front end. It takes one bit that says whether the received power is above a switching threshold, and it drives one bit that selects low gain (1) or high gain (0). When the power is above the threshold, the block moves to low gain at once. After the power falls back below the threshold, the block keeps low gain for a programmable hold-off of 2^N reference-clock cycles. It goes back to high gain only if the power is still below the threshold when that hold-off ends. Any new excursion above the threshold clears the hold-off, and the count starts again from zero.

The hold-off prevents the front end from switching gain on every symbol of an amplitude-keyed stream. The stream's high level can sit above the threshold and its low level below it. The exponent N lives in a configuration word at address 0xA of the block's configuration map. A write to any other address leaves it unchanged. Values above the largest supported exponent are clamped to that maximum.

Top module: `agc_dwell_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, `gain_low` is 0 (high gain) and the hold-off exponent is RESET_EXP (13 by default).
- R2: A clock edge that samples `pwr_above` = 1 sets `gain_low` to 1 after that edge, whatever the previous gain was.
- R3: In low gain, `gain_low` returns to 0 right after the edge that completes 2^N consecutive samples of `pwr_above` = 0, where N is the current exponent. N = 0 gives a hold-off of one sample.
- R4: A sample of `pwr_above` = 1 during the hold-off clears the count. The next fall starts a full 2^N hold-off from zero.
- R5: In high gain, samples of `pwr_above` = 0 leave `gain_low` at 0.
- R6: An edge with `cfg_we` = 1 and `cfg_addr` = 0xA loads `cfg_wdata` into the exponent. The new value governs from the following edge. A write to any other address has no effect on the hold-off length.
- R7: A written value greater than MAX_EXP (20 by default) is stored as MAX_EXP.
- R8: A change of exponent during a hold-off applies at once. If the samples already counted reach the new length, high gain returns on the next below-threshold edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pwr_above | input | 1 | 1 when received power is above the switching threshold |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration address; the exponent sits at 0xA |
| cfg_wdata | input | 8 | Configuration write data |
| gain_low | output | 1 | 1 selects low gain, 0 selects high gain |

## Verification
On every cycle the assertions check the following:
- Each rise of `gain_low` follows a sample of power above the threshold, and each fall follows a sample below it.
- The hold-off counter is zero whenever it is not counting.
- The stored exponent never exceeds its ceiling.

Only the bench scenarios can show the exact hold-off lengths: the default 2^13 hold-off, the N = 0 boundary, restarts after a brief return above the threshold, ignored writes to other addresses, clamping at two different ceilings, and an exponent cut in the middle of a hold-off. The bench compares the gain output cycle by cycle against a model built from the requirements.

// File: rtl/agc_dwell_pkg.sv
// Shared types for the gain switch. Assumes nothing beyond IEEE 1800-2017.
package agc_dwell_pkg;
    typedef enum logic {
        GAIN_HIGH = 1'b0,
        GAIN_LOW  = 1'b1
    } gain_e;
endpackage

// File: rtl/agc_dwell_cfg.sv
// Holds the hold-off exponent register.
// Decodes writes to DWELL_ADDR only and clamps values above MAX_EXP.
// Assumes MAX_EXP fits in DATA_W bits and RESET_EXP <= MAX_EXP.
module agc_dwell_cfg #(
    parameter int unsigned ADDR_W     = 4,
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned MAX_EXP    = 20,
    parameter int unsigned RESET_EXP  = 13,
    parameter int unsigned DWELL_ADDR = 4'hA,
    localparam int unsigned EXP_W     = $clog2(MAX_EXP + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [EXP_W-1:0]  exp_o
);
    logic             hit;
    logic [EXP_W-1:0] clamped;

    // Address match and clamping of the write value.
    always_comb begin
        hit     = cfg_we && (cfg_addr == ADDR_W'(DWELL_ADDR));
        clamped = (cfg_wdata > DATA_W'(MAX_EXP)) ? EXP_W'(MAX_EXP)
                                                 : EXP_W'(cfg_wdata);
    end

    // Exponent register with its reset value.
    always_ff @(posedge clk) begin
        if (!rst_n)   exp_o <= EXP_W'(RESET_EXP);
        else if (hit) exp_o <= clamped;
    end

    // R7: the stored exponent never exceeds its ceiling.
    a_r7_exp_capped: assert property (@(posedge clk) disable iff (!rst_n)
        exp_o <= EXP_W'(MAX_EXP));
endmodule

// File: rtl/agc_dwell_timer.sv
// Counts consecutive below-threshold samples while in low gain.
// Flags expiry when 2^exp_i samples have been counted.
// Assumes CNT_W > the largest exponent, so 1 << exp_i never overflows.
module agc_dwell_timer #(
    parameter int unsigned EXP_W = 5,
    parameter int unsigned CNT_W = 21
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [EXP_W-1:0] exp_i,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;

    // Last count value of the current hold-off; it compares against a live exponent.
    always_comb begin
        last    = (CNT_W'(1) << exp_i) - CNT_W'(1);
        expired = run && (cnt >= last);
    end

    // Counter: cleared when idle or on expiry, otherwise advanced.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || expired) cnt <= '0;
        else                           cnt <= cnt + CNT_W'(1);
    end

    // R4: the count is zero after any cycle in which it was not running.
    a_r4_cleared_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> cnt == '0);
endmodule

// File: rtl/agc_gain_fsm.sv
// Gain state: forced low by above-threshold power, released by timer expiry.
// Assumes 'expired' can only be high while in low gain with power below threshold.
module agc_gain_fsm
    import agc_dwell_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_above,
    input  logic expired,
    output logic gain_low
);
    gain_e state;

    // Next gain: above-threshold power wins, expiry releases, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)         state <= GAIN_HIGH;
        else if (pwr_above) state <= GAIN_LOW;
        else if (expired)   state <= GAIN_HIGH;
    end

    assign gain_low = (state == GAIN_LOW);

    // R1: reset yields high gain.
    a_r1_reset_high: assert property (@(posedge clk)
        !rst_n |=> !gain_low);
    // R2: an above-threshold sample gives low gain next cycle.
    a_r2_above_forces_low: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_above |=> gain_low);
    // R5: low gain is only entered after an above-threshold sample.
    a_r5_rise_needs_above: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gain_low) |-> $past(pwr_above));
    // R3: high gain only returns after a below-threshold sample.
    a_r3_fall_needs_below: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gain_low) |-> !$past(pwr_above));
endmodule

// File: rtl/agc_dwell_ctrl.sv
// Top of the gain switch: exponent register, hold-off timer and gain state.
// Assumes pwr_above is already synchronous to clk.
module agc_dwell_ctrl #(
    parameter int unsigned ADDR_W     = 4,
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned MAX_EXP    = 20,
    parameter int unsigned RESET_EXP  = 13,
    parameter int unsigned DWELL_ADDR = 4'hA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_above,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic              gain_low
);
    localparam int unsigned EXP_W = $clog2(MAX_EXP + 1);
    localparam int unsigned CNT_W = MAX_EXP + 1;

    logic [EXP_W-1:0] exp_q;
    logic             run;
    logic             expired;

    // The timer counts only in low gain with power below the threshold.
    assign run = gain_low && !pwr_above;

    agc_dwell_cfg #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_EXP(MAX_EXP),
        .RESET_EXP(RESET_EXP), .DWELL_ADDR(DWELL_ADDR)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .exp_o(exp_q)
    );

    agc_dwell_timer #(.EXP_W(EXP_W), .CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(run), .exp_i(exp_q), .expired(expired)
    );

    agc_gain_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .pwr_above(pwr_above),
        .expired(expired), .gain_low(gain_low)
    );
endmodule

// File: tb/agc_dwell_ctrl_tb.sv
`timescale 1ns/1ps
module agc_dwell_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_above = 1'b0;
    logic       cfg_we = 1'b0;
    logic [3:0] cfg_addr = 4'h0;
    logic [7:0] cfg_wdata = 8'h0;
    logic       gain_big, gain_small;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // Reference model state; index 0 is the default instance, index 1 the small one.
    bit m_low [2];
    int m_cnt [2];
    int m_exp [2];
    int m_max [2] = '{20, 4};
    int m_rst [2] = '{13, 4};

    always #4 clk = ~clk;

    agc_dwell_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .pwr_above(pwr_above), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .gain_low(gain_big)
    );

    agc_dwell_ctrl #(.MAX_EXP(4), .RESET_EXP(4)) u_dut_small (
        .clk(clk), .rst_n(rst_n), .pwr_above(pwr_above), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .gain_low(gain_small)
    );

    function automatic int clamp_exp(int i, logic [7:0] d);
        return (int'(d) > m_max[i]) ? m_max[i] : int'(d);
    endfunction

    // One clock edge of the requirement model (R2, R3, R4, R6, R7, R8).
    task automatic model_edge(int i, bit ab, bit we, logic [3:0] a, logic [7:0] d);
        int lim = 1 << m_exp[i];
        if (ab) begin
            m_low[i] = 1; m_cnt[i] = 0;
        end else if (m_low[i]) begin
            if (m_cnt[i] >= lim - 1) begin m_low[i] = 0; m_cnt[i] = 0; end
            else m_cnt[i]++;
        end
        if (we && a == 4'hA) m_exp[i] = clamp_exp(i, d);
    endtask

    task automatic check(string tag);
        total++;
        if (gain_big !== m_low[0]) begin
            bad++;
            $display("FAIL %s default instance: gain_low=%b expected=%b", tag, gain_big, m_low[0]);
        end
        total++;
        if (gain_small !== m_low[1]) begin
            bad++;
            $display("FAIL %s small instance: gain_low=%b expected=%b", tag, gain_small, m_low[1]);
        end
    endtask

    task automatic step(bit ab, bit we, logic [3:0] a, logic [7:0] d, string tag);
        pwr_above = ab; cfg_we = we; cfg_addr = a; cfg_wdata = d;
        @(posedge clk);
        for (int i = 0; i < 2; i++) model_edge(i, ab, we, a, d);
        @(negedge clk);
        cfg_we = 1'b0;
        check(tag);
    endtask

    task automatic run_below(int n, string tag);
        for (int k = 0; k < n; k++) step(0, 0, 4'h0, 8'h0, tag);
    endtask

    initial begin
        for (int i = 0; i < 2; i++) begin m_low[i] = 0; m_cnt[i] = 0; m_exp[i] = m_rst[i]; end
        repeat (3) @(negedge clk);
        check("R1 in reset");
        rst_n = 1'b1;
        run_below(5, "R5 stays high");
        check("R1 after reset");
        // R2 then the R1 default hold-off (2^13) checked on every cycle.
        step(1, 0, 4'h0, 8'h0, "R2 enter low");
        run_below(8192 + 3, "R3 default hold-off");
        // R6: a write to another address is ignored; the hold-off stays 2^13.
        step(1, 1, 4'h5, 8'h02, "R6 other address");
        run_below(8192 + 3, "R6 ignored write");
        // R6 load 3, then R4 restart mid hold-off.
        step(1, 1, 4'hA, 8'h03, "R6 load");
        run_below(5, "R4 partial");
        step(1, 0, 4'h0, 8'h0, "R4 re-rise");
        run_below(10, "R4 full restart");
        // R7: 255 clamps to 20 and 4. Then R8: the exponent is cut during the hold-off.
        step(1, 1, 4'hA, 8'hFF, "R7 clamp write");
        run_below(20, "R7 clamp hold-off");
        step(0, 1, 4'hA, 8'h03, "R8 shrink");
        run_below(3, "R8 after shrink");
        // R3 boundary: N = 0 gives a one-sample hold-off.
        step(1, 1, 4'hA, 8'h00, "R3 zero load");
        step(1, 0, 4'h0, 8'h0, "R3 zero enter");
        run_below(3, "R3 zero exponent");
        // Random mix with a fixed seed.
        void'($urandom(32'h5EED_1234));
        for (int k = 0; k < 6000; k++) begin
            bit ab = ($urandom % 100) < 30;
            bit we = ($urandom % 100) < 3;
            logic [3:0] a = ($urandom % 2) ? 4'hA : 4'($urandom);
            logic [7:0] d = 8'($urandom % 7);
            if (a == 4'hA && !we) a = 4'h0;
            step(ab, we, a, d, "R2-R8 random");
        end
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule